// File: doc/BRIEF.md
# Register Read-After-Write Hazard Scoreboard

This block sits beside the decode stage of an in-order pipeline and remembers which architectural registers still have a result on its way. Each register is one bit of a one-hot mask, and the block holds a pending mask with one bit per register. When decode lets an instruction go, its destination registers join the pending set. When writeback writes a register, the writeback side names it in a retire mask and the register leaves the set.

Each cycle, decode presents the source-register mask of the instruction it holds. The block grants the sources that are not pending, up to a fixed number of read ports. Grants go to the lowest register index first. Any source left over, whether it is pending or beyond the port limit, raises the stall output. The stall holds decode and the fetch stage in front of it. Reads that are granted in a stalled cycle are used up. On the retry the block asks only for the sources still outstanding, and it tracks them in a small two-state slot machine.

The slot machine has two states. In SLOT_FRESH the request is the presented source mask. In SLOT_RETRY the request is the stored remainder. The transitions are:
- fresh_to_retry: a valid attempt in SLOT_FRESH stalls.
- retry_to_fresh: a valid attempt in SLOT_RETRY does not stall.
- In every other case the state does not change.

Top module: `raw_scoreboard`

## Requirements
- R1: After reset the pending set is empty. The first valid instruction is granted every source, up to the port limit, and does not stall because of a hazard.
- R2: A valid attempt that does not stall adds its destination mask to the pending set from the next cycle on.
- R3: A register named in the retire mask leaves the pending set from the next cycle on, unless R7 applies to it.
- R4: A source register that is pending is never granted. Its presence raises the stall output.
- R5: At most READ_PORTS grants are made per cycle (default 3), and they go to the lowest register index first. Any source not granted raises the stall output.
- R6: Sources granted in a stalled cycle are removed from the request. The next attempt requests only the remaining sources, and a granted source is never granted again for the same instruction.
- R7: If one cycle both reserves and retires the same register, the register stays pending.
- R8: While dec_valid is low, the stall output and the grant mask are zero, and the destination mask reserves nothing.
- R9: A retire takes effect only from the next cycle. A read of the retiring register in the same cycle is still refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds an instruction. It must stay high, with the same masks, while the stall output is high |
| dec_src_mask | input | NUM_REGS | One-hot-per-register source mask |
| dec_dst_mask | input | NUM_REGS | One-hot-per-register destination mask |
| wb_retire_mask | input | NUM_REGS | Registers written back this cycle |
| dec_stall | output | 1 | Hold decode and fetch |
| rd_grant_mask | output | NUM_REGS | Source reads granted this cycle |

## Verification
A wrong pending bit shows up at the ports on the first later read of that register. A bit that was lost lets a dependent read through when it should have stalled. A bit that sticks stalls that read for ever. An error in the remainder register or in the slot state shows up one cycle after a stalled attempt: the retry either grants a source a second time or loses one. The bench compares every cycle against a model of the requirements, so each such error is reported in the cycle in which it first shows at the ports.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [0:0] {
        SLOT_FRESH = 1'b0,
        SLOT_RETRY = 1'b1
    } slot_state_e;
endpackage

// File: rtl/sb_read_arbiter.sv
module sb_read_arbiter #(
    parameter int WIDTH = 32,
    parameter int PORTS = 3
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] grant
);
    localparam int CW = $clog2(PORTS + 1);

    generate
        if (PORTS >= WIDTH) begin : g_all
            assign grant = req;
        end else begin : g_limit
            always_comb begin
                logic [CW-1:0] used;
                used  = '0;
                grant = '0;
                for (int i = 0; i < WIDTH; i++) begin
                    if (req[i] && (used < CW'(PORTS))) begin
                        grant[i] = 1'b1;
                        used     = used + CW'(1);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sb_pending_set.sv
module sb_pending_set #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reserve_en,
    input  logic [WIDTH-1:0] reserve_mask,
    input  logic [WIDTH-1:0] retire_mask,
    output logic [WIDTH-1:0] pending
);
    logic [WIDTH-1:0] pend_d;

    always_comb begin
        pend_d = pending & ~retire_mask;
        if (reserve_en) begin
            pend_d = pend_d | reserve_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            pending <= pend_d;
        end
    end
endmodule

// File: rtl/sb_decode_ctrl.sv
module sb_decode_ctrl
    import sb_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [WIDTH-1:0] src_mask,
    input  logic [WIDTH-1:0] grant_mask,
    input  logic             stall,
    output logic [WIDTH-1:0] need_mask
);
    slot_state_e      state_q, state_d;
    logic [WIDTH-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FRESH;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (dec_valid && stall) begin
                rem_q <= need_mask & ~grant_mask;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FRESH: if (dec_valid && stall)  state_d = SLOT_RETRY;
            SLOT_RETRY: if (dec_valid && !stall) state_d = SLOT_FRESH;
            default:    state_d = SLOT_FRESH;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SLOT_FRESH: need_mask = src_mask;
            SLOT_RETRY: need_mask = rem_q;
            default:    need_mask = src_mask;
        endcase
    end
endmodule

// File: rtl/raw_scoreboard.sv
module raw_scoreboard #(
    parameter int NUM_REGS   = 32,
    parameter int READ_PORTS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dec_valid,
    input  logic [NUM_REGS-1:0] dec_src_mask,
    input  logic [NUM_REGS-1:0] dec_dst_mask,
    input  logic [NUM_REGS-1:0] wb_retire_mask,
    output logic                dec_stall,
    output logic [NUM_REGS-1:0] rd_grant_mask
);
    logic [NUM_REGS-1:0] pending_q;
    logic [NUM_REGS-1:0] need;
    logic [NUM_REGS-1:0] avail;
    logic [NUM_REGS-1:0] arb_grant;
    logic                accept;

    assign avail         = dec_valid ? (need & ~pending_q) : '0;
    assign rd_grant_mask = arb_grant;
    assign dec_stall     = dec_valid && ((need & ~arb_grant) != '0);
    assign accept        = dec_valid && !dec_stall;

    sb_decode_ctrl #(.WIDTH(NUM_REGS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_valid  (dec_valid),
        .src_mask   (dec_src_mask),
        .grant_mask (arb_grant),
        .stall      (dec_stall),
        .need_mask  (need)
    );

    sb_read_arbiter #(.WIDTH(NUM_REGS), .PORTS(READ_PORTS)) u_arb (
        .req   (avail),
        .grant (arb_grant)
    );

    sb_pending_set #(.WIDTH(NUM_REGS)) u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .reserve_en   (accept),
        .reserve_mask (dec_dst_mask),
        .retire_mask  (wb_retire_mask),
        .pending      (pending_q)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NUM_REGS   = 32,
    parameter int READ_PORTS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dec_valid,
    input logic [NUM_REGS-1:0] dec_dst_mask,
    input logic [NUM_REGS-1:0] wb_retire_mask,
    input logic                dec_stall,
    input logic [NUM_REGS-1:0] rd_grant_mask,
    input logic [NUM_REGS-1:0] pending_q
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> pending_q == '0);

    assert_reserve_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_stall) |=> ((pending_q & $past(dec_dst_mask)) == $past(dec_dst_mask)));

    assert_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_valid && !dec_stall) |=> ((pending_q & $past(wb_retire_mask)) == '0));

    assert_no_pending_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant_mask & pending_q) == '0);

    assert_grant_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_grant_mask) <= READ_PORTS);

    assert_no_regrant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dec_valid && dec_stall) && dec_valid) |-> ((rd_grant_mask & $past(rd_grant_mask)) == '0));

    assert_reserve_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_stall && ((dec_dst_mask & wb_retire_mask) != '0))
        |=> ((pending_q & $past(dec_dst_mask & wb_retire_mask)) == $past(dec_dst_mask & wb_retire_mask)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_stall && rd_grant_mask == '0));
endmodule

bind raw_scoreboard sb_checker #(.NUM_REGS(NUM_REGS), .READ_PORTS(READ_PORTS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .dec_valid      (dec_valid),
    .dec_dst_mask   (dec_dst_mask),
    .wb_retire_mask (wb_retire_mask),
    .dec_stall      (dec_stall),
    .rd_grant_mask  (rd_grant_mask),
    .pending_q      (pending_q)
);

// File: tb/sim_raw_scoreboard.sv
module sim_raw_scoreboard;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dec_valid = 1'b0;
    logic [N-1:0] dec_src_mask = '0;
    logic [N-1:0] dec_dst_mask = '0;
    logic [N-1:0] wb_retire_mask = '0;
    logic         dec_stall;
    logic [N-1:0] rd_grant_mask;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_rem  = '0;
    bit           m_retry = 1'b0;
    logic [31:0]  lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    raw_scoreboard u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid),
        .dec_src_mask(dec_src_mask), .dec_dst_mask(dec_dst_mask),
        .wb_retire_mask(wb_retire_mask), .dec_stall(dec_stall),
        .rd_grant_mask(rd_grant_mask)
    );

    function automatic logic [N-1:0] low3(input logic [N-1:0] x);
        logic [N-1:0] r = x;
        for (int k = 0; k < 3; k++) r = r & (r - 1);
        return x ^ r;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit v, input logic [N-1:0] src,
                        input logic [N-1:0] dst, input logic [N-1:0] ret);
        logic [N-1:0] need, g;
        bit st;
        @(negedge clk);
        dec_valid = v; dec_src_mask = src; dec_dst_mask = dst; wb_retire_mask = ret;
        #1;
        need = m_retry ? m_rem : src;
        g    = v ? low3(need & ~m_pend) : '0;
        st   = v && ((need & ~g) != '0);
        check({tag, " grant"}, rd_grant_mask, g);
        check({tag, " stall"}, {{(N-1){1'b0}}, dec_stall}, {{(N-1){1'b0}}, st});
        @(posedge clk);
        m_pend = (m_pend & ~ret) | ((v && !st) ? dst : '0);
        if (v && st) begin m_retry = 1'b1; m_rem = need & ~g; end
        else if (v) m_retry = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: empty after reset, three sources all granted
        step("R1", 1, 32'h0000_0049, '0, '0);
        check("R1 hard", rd_grant_mask, 32'h0000_0049);
        // R5 and R6: eight sources take three attempts
        step("R5 first", 1, 32'h0000_00FF, '0, '0);
        step("R6 retry1", 1, 32'h0000_00FF, '0, '0);
        step("R6 retry2", 1, 32'h0000_00FF, '0, '0);
        // R2 and R4: reserve r5, then a reader of r5 stalls
        step("R2 reserve", 1, '0, 32'h20, '0);
        step("R4 hazard", 1, 32'h21, '0, '0);
        // R9: retire in the same cycle is still refused
        step("R9 same", 1, 32'h21, '0, 32'h20);
        step("R3 after", 1, 32'h21, '0, '0);
        // R7: reserve and retire r7 together
        step("R7 both", 1, '0, 32'h80, '0);
        step("R7 both2", 1, '0, 32'h80, 32'h80);
        step("R7 read", 1, 32'h80, '0, '0);
        step("R7 clear", 0, '0, '0, 32'h80);
        step("R7 ok", 1, 32'h80, '0, '0);
        // R8: idle destination reserves nothing
        step("R8 idle", 0, 32'hF, 32'h200, '0);
        step("R8 read", 1, 32'h200, '0, '0);
        // R2/R3/R4 sweep over every register
        for (int i = 0; i < N; i++) begin
            step("R2 sweep", 1, '0, 32'h1 << i, '0);
            step("R4 sweep", 1, 32'h1 << i, '0, '0);
            step("R3 sweep", 0, '0, '0, 32'h1 << i);
            step("R3 sweep rd", 1, 32'h1 << i, '0, '0);
        end
        // R5/R6 randomized traffic against the model
        for (int c = 0; c < 3000; c++) begin
            logic [N-1:0] s, d, r;
            bit v;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            s = lfsr & {lfsr[15:0], lfsr[31:16]} & {lfsr[7:0], lfsr[31:8]};
            d = 32'h1 << lfsr[4:0];
            r = m_pend & {lfsr[23:0], lfsr[31:24]};
            v = lfsr[9] | lfsr[3];
            if (m_retry) begin v = 1'b1; s = dec_src_mask; d = dec_dst_mask; end
            step("R6 random", v, s, d, r);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule